// File: doc/BRIEF.md
# Four-Segment In-Order Pipeline with Branch Freeze

This block is a small in-order processor core. Each instruction passes through four segments in a fixed order: instruction fetch (IF), decode (DC), operand fetch (OF) and execute (EX). Instruction memory and data memory are separate arrays inside the block, so a fetch and an operand read can happen in the same cycle. The instruction memory is filled through a write port, normally while reset is held. The data memory starts from a fixed pattern that is computed at reset.

A branch seen in DC freezes the IF-to-DC transfer until that branch has executed. A branch that falls through reuses the word already held in IF. A taken branch discards the held word and fetches from the target. An interrupt request lets the instruction in EX finish, empties the younger segments and restarts at a fixed vector. A load waiting in OF is held back by one cycle when the instruction in EX is writing data memory. The block reports each completed instruction on a retire strobe with its PC, register writeback fields and store fields. A testbench can compare this stream against an instruction-level model.

Branch control is a three-state machine. ST_RUN is the free-flowing state. It moves to ST_BR_OPER when a branch leaves DC, unless an interrupt or a memory stall is present in that cycle. ST_BR_OPER (branch in OF, IF frozen) moves to ST_BR_EXEC, or back to ST_RUN on an interrupt. ST_BR_EXEC (branch in EX, resolving) always returns to ST_RUN.

Top module: `fsp_core`

## Requirements
- R1: Instruction words are 16 bits wide and are laid out as follows: opcode in [15:12], rd in [11:9], ra in [8:6], rb in [5:3], and an 8-bit immediate in [7:0]. Opcode 1 computes rd = ra + rb and opcode 2 computes rd = ra - rb, both mod 256. Opcode 3 loads the immediate into rd. The eight 8-bit registers reset to 0. In the cycle an instruction retires, the writeback port shows the destination register and the value written.
- R2: Opcode 4 (load) copies data word [3:0] into rd. Opcode 5 (store) writes rd into data word [3:0] and shows the address and data on the store port. After reset, data word i holds (7*i + 3) mod 256.
- R3: While reset is held, nothing retires. The first instruction, at PC RESET_PC, retires exactly 4 cycles after reset is released. Code without branches retires one instruction per cycle in program order. Words written through the program port are the words fetched.
- R4: Opcode 6 is branch-if-zero. It tests register rd, and its target is word [5:0]. While the branch is in DC or OF, no new instruction enters DC. If rd is not zero, the next instruction retires 3 cycles after the branch, at the branch PC plus 1, taken from the word already held in IF.
- R5: If rd is zero, the next instruction retires 4 cycles after the branch, at the target. Words fetched behind the branch never retire.
- R6: A load in OF behind a store in EX waits one cycle. The load retires 2 cycles after the store and returns the value just stored.
- R7: In a cycle where the interrupt input is high, the instruction in EX completes and every younger instruction is discarded. The next instruction to retire is at IRQ_VEC, exactly 4 cycles later.
- R8: An interrupt in the same cycle as a taken branch in EX sends fetch to IRQ_VEC, not to the branch target.
- R9: The retire strobe pulses once for each completed instruction. The writeback enable is set only for opcodes 1 to 4, and the store enable only for opcode 5. Opcode 0 and opcodes 7 to 15 retire with no register or memory effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_i | input | 1 | Interrupt request, acted on in each cycle it is high |
| prog_we_i | input | 1 | Instruction memory write enable |
| prog_addr_i | input | $clog2(IMEM_DEPTH) | Instruction memory write address |
| prog_data_i | input | 16 | Instruction word to write |
| retire_o | output | 1 | An instruction completes this cycle |
| retire_pc_o | output | $clog2(IMEM_DEPTH) | PC of the completing instruction |
| wb_en_o | output | 1 | Register write this cycle |
| wb_reg_o | output | 3 | Destination register |
| wb_data_o | output | 8 | Value written |
| st_en_o | output | 1 | Data memory store this cycle |
| st_addr_o | output | $clog2(DMEM_DEPTH) | Store address |
| st_data_o | output | 8 | Store data |

## Verification
Arithmetic is checked by sweeping operand pairs that include 0, 1, 127, 128 and 255. These pairs separate correct wrap-around from sign or carry mistakes. A load from every data word checks the reset pattern, and store-then-load pairs to the same and to different addresses separate the contention stall from plain ordering. A counting loop produces both taken and fall-through branches, which shows whether the held word is reused and whether the wrong path is discarded. Finally, a single interrupt pulse is placed in every cycle of a program that mixes stores, loads and branches. This covers flushes during the fill, during a stall, in a branch shadow, and against a taken branch.

// File: rtl/fsp_pkg.sv
package fsp_pkg;
    localparam int IW = 16;   // instruction width
    localparam int DW = 8;    // register width
    localparam int RW = 3;    // register index width
    localparam int NREG = 1 << RW;

    typedef logic [3:0] opc_t;
    localparam opc_t OP_NOP   = 4'd0;
    localparam opc_t OP_ADD   = 4'd1;
    localparam opc_t OP_SUB   = 4'd2;
    localparam opc_t OP_LDI   = 4'd3;
    localparam opc_t OP_LOAD  = 4'd4;
    localparam opc_t OP_STORE = 4'd5;
    localparam opc_t OP_BEQZ  = 4'd6;

    typedef enum logic [1:0] {
        ST_RUN     = 2'd0,
        ST_BR_OPER = 2'd1,
        ST_BR_EXEC = 2'd2
    } ctl_st_e;

    function automatic opc_t op_of(input logic [IW-1:0] ir);
        return ir[IW-1 -: 4];
    endfunction
endpackage

// File: rtl/fsp_ctrl.sv
module fsp_ctrl
    import fsp_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    irq_i,
    input  logic    d_br_i,
    input  logic    stall_i,
    output logic    hold_o,
    output ctl_st_e st_o
);
    ctl_st_e st_q, st_d;

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_RUN;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_RUN:     st_d = (d_br_i && !irq_i && !stall_i) ? ST_BR_OPER : ST_RUN;
            ST_BR_OPER: st_d = irq_i ? ST_RUN : ST_BR_EXEC;
            ST_BR_EXEC: st_d = ST_RUN;
            default:    st_d = ST_RUN;
        endcase
    end

    always_comb begin
        st_o   = st_q;
        hold_o = (st_q == ST_BR_OPER) || ((st_q == ST_RUN) && d_br_i);
    end
endmodule

// File: rtl/fsp_mem.sv
module fsp_mem #(
    parameter int DEPTH    = 16,
    parameter int DW       = 8,
    parameter int INIT_MUL = 0,
    parameter int INIT_ADD = 0,
    localparam int AW      = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          init_i,
    input  logic          we_i,
    input  logic [AW-1:0] wa_i,
    input  logic [DW-1:0] wd_i,
    input  logic [AW-1:0] ra_i,
    output logic [DW-1:0] rd_o
);
    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (init_i) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= DW'(i * INIT_MUL + INIT_ADD);
        end else if (we_i) begin
            mem[wa_i] <= wd_i;
        end
    end

    assign rd_o = mem[ra_i];
endmodule

// File: rtl/fsp_regfile.sv
module fsp_regfile
    import fsp_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we_i,
    input  logic [RW-1:0] wa_i,
    input  logic [DW-1:0] wd_i,
    input  logic [RW-1:0] ra_i,
    input  logic [RW-1:0] rb_i,
    input  logic [RW-1:0] rc_i,
    output logic [DW-1:0] a_o,
    output logic [DW-1:0] b_o,
    output logic [DW-1:0] c_o
);
    logic [DW-1:0] rf [NREG];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) rf[i] <= '0;
        end else if (we_i) begin
            rf[wa_i] <= wd_i;
        end
    end

    assign a_o = rf[ra_i];
    assign b_o = rf[rb_i];
    assign c_o = rf[rc_i];
endmodule

// File: rtl/fsp_exec.sv
module fsp_exec
    import fsp_pkg::*;
(
    input  logic          vld_i,
    input  opc_t          op_i,
    input  logic [DW-1:0] imm_i,
    input  logic [DW-1:0] a_i,
    input  logic [DW-1:0] b_i,
    input  logic [DW-1:0] c_i,
    input  logic [DW-1:0] ld_i,
    output logic          wb_en_o,
    output logic [DW-1:0] wb_data_o,
    output logic          st_en_o,
    output logic          taken_o
);
    always_comb begin
        wb_en_o   = 1'b0;
        wb_data_o = '0;
        st_en_o   = 1'b0;
        taken_o   = 1'b0;
        if (vld_i) begin
            unique case (op_i)
                OP_ADD:   begin wb_en_o = 1'b1; wb_data_o = a_i + b_i; end
                OP_SUB:   begin wb_en_o = 1'b1; wb_data_o = a_i - b_i; end
                OP_LDI:   begin wb_en_o = 1'b1; wb_data_o = imm_i;     end
                OP_LOAD:  begin wb_en_o = 1'b1; wb_data_o = ld_i;      end
                OP_STORE: st_en_o = 1'b1;
                OP_BEQZ:  taken_o = (c_i == '0);
                default:  ;
            endcase
        end
    end
endmodule

// File: rtl/fsp_core.sv
module fsp_core
    import fsp_pkg::*;
#(
    parameter int IMEM_DEPTH = 64,
    parameter int DMEM_DEPTH = 16,
    parameter int RESET_PC   = 0,
    parameter int IRQ_VEC    = 48
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          irq_i,
    input  logic                          prog_we_i,
    input  logic [$clog2(IMEM_DEPTH)-1:0] prog_addr_i,
    input  logic [15:0]                   prog_data_i,
    output logic                          retire_o,
    output logic [$clog2(IMEM_DEPTH)-1:0] retire_pc_o,
    output logic                          wb_en_o,
    output logic [2:0]                    wb_reg_o,
    output logic [7:0]                    wb_data_o,
    output logic                          st_en_o,
    output logic [$clog2(DMEM_DEPTH)-1:0] st_addr_o,
    output logic [7:0]                    st_data_o
);
    localparam int PC_W = $clog2(IMEM_DEPTH);
    localparam int DA_W = $clog2(DMEM_DEPTH);

    // Segment registers: IF, DC, OF, EX
    logic            f_v, d_v, o_v, e_v;
    logic [PC_W-1:0] f_pc, d_pc, o_pc, e_pc, pc_q;
    logic [IW-1:0]   f_ir, d_ir, o_ir, e_ir;
    logic [DW-1:0]   e_opnd;

    logic            hold_fd, stall_mem, taken, redirect, d_br;
    logic [PC_W-1:0] redir_pc, fetch_pc, br_tgt;
    logic [IW-1:0]   im_rd;
    logic [DW-1:0]   dm_rd, ra_v, rb_v, rc_v, wb_data;
    logic            wb_en, st_en;
    ctl_st_e         ctl_st;

    assign d_br      = d_v && (op_of(d_ir) == OP_BEQZ);
    assign stall_mem = e_v && (op_of(e_ir) == OP_STORE) && o_v && (op_of(o_ir) == OP_LOAD);
    assign br_tgt    = e_ir[PC_W-1:0];
    assign redirect  = irq_i || taken;
    assign redir_pc  = irq_i ? PC_W'(IRQ_VEC) : br_tgt;
    assign fetch_pc  = redirect ? redir_pc : pc_q;

    fsp_ctrl u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .irq_i   (irq_i),
        .d_br_i  (d_br),
        .stall_i (stall_mem),
        .hold_o  (hold_fd),
        .st_o    (ctl_st)
    );

    fsp_mem #(.DEPTH(IMEM_DEPTH), .DW(IW), .INIT_MUL(0), .INIT_ADD(0)) u_imem (
        .clk    (clk),
        .init_i (1'b0),
        .we_i   (prog_we_i),
        .wa_i   (prog_addr_i),
        .wd_i   (prog_data_i),
        .ra_i   (fetch_pc),
        .rd_o   (im_rd)
    );

    fsp_mem #(.DEPTH(DMEM_DEPTH), .DW(DW), .INIT_MUL(7), .INIT_ADD(3)) u_dmem (
        .clk    (clk),
        .init_i (!rst_n),
        .we_i   (st_en),
        .wa_i   (e_ir[DA_W-1:0]),
        .wd_i   (rc_v),
        .ra_i   (o_ir[DA_W-1:0]),
        .rd_o   (dm_rd)
    );

    fsp_regfile u_rf (
        .clk   (clk),
        .rst_n (rst_n),
        .we_i  (wb_en),
        .wa_i  (e_ir[11:9]),
        .wd_i  (wb_data),
        .ra_i  (e_ir[8:6]),
        .rb_i  (e_ir[5:3]),
        .rc_i  (e_ir[11:9]),
        .a_o   (ra_v),
        .b_o   (rb_v),
        .c_o   (rc_v)
    );

    fsp_exec u_exec (
        .vld_i     (e_v),
        .op_i      (op_of(e_ir)),
        .imm_i     (e_ir[7:0]),
        .a_i       (ra_v),
        .b_i       (rb_v),
        .c_i       (rc_v),
        .ld_i      (e_opnd),
        .wb_en_o   (wb_en),
        .wb_data_o (wb_data),
        .st_en_o   (st_en),
        .taken_o   (taken)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q <= PC_W'(RESET_PC);
            f_v <= 1'b0; d_v <= 1'b0; o_v <= 1'b0; e_v <= 1'b0;
            f_pc <= '0;  d_pc <= '0;  o_pc <= '0;  e_pc <= '0;
            f_ir <= '0;  d_ir <= '0;  o_ir <= '0;  e_ir <= '0;
            e_opnd <= '0;
        end else if (redirect) begin
            // Interrupt or taken branch: EX commits, younger work is dropped
            f_v  <= 1'b1;
            f_pc <= redir_pc;
            f_ir <= im_rd;
            pc_q <= redir_pc + 1'b1;
            d_v  <= 1'b0;
            o_v  <= 1'b0;
            e_v  <= 1'b0;
        end else if (stall_mem) begin
            // Load in OF waits for the store in EX to use the data port
            e_v <= 1'b0;
        end else begin
            e_v    <= o_v;
            e_pc   <= o_pc;
            e_ir   <= o_ir;
            e_opnd <= dm_rd;
            o_v    <= d_v;
            o_pc   <= d_pc;
            o_ir   <= d_ir;
            if (hold_fd) begin
                d_v <= 1'b0;
            end else begin
                d_v  <= f_v;
                d_pc <= f_pc;
                d_ir <= f_ir;
                f_v  <= 1'b1;
                f_pc <= pc_q;
                f_ir <= im_rd;
                pc_q <= pc_q + 1'b1;
            end
        end
    end

    assign retire_o    = e_v;
    assign retire_pc_o = e_pc;
    assign wb_en_o     = wb_en;
    assign wb_reg_o    = e_ir[11:9];
    assign wb_data_o   = wb_data;
    assign st_en_o     = st_en;
    assign st_addr_o   = e_ir[DA_W-1:0];
    assign st_data_o   = rc_v;

    // Branch window: segments behind a resolving branch carry bubbles
    assert_branch_shadow_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (e_v && op_of(e_ir) == OP_BEQZ) |-> (!d_v && !o_v));

    assert_fd_freeze_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (d_br && !irq_i && !stall_mem) |=> (!d_v && $stable(f_pc) && $stable(pc_q)));

    assert_oper_state_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_st == ST_BR_OPER) |-> (o_v && op_of(o_ir) == OP_BEQZ));

    assert_exec_state_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_st == ST_BR_EXEC) |-> (e_v && op_of(e_ir) == OP_BEQZ));

    assert_taken_target_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (taken && !irq_i) |=> (f_v && f_pc == $past(br_tgt)));

    assert_mem_wait_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (stall_mem && !irq_i) |=> (!e_v && o_v && $stable(o_pc)));

    assert_irq_flush_R7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_i |=> (!d_v && !o_v && !e_v && f_v));

    assert_irq_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_i && taken) |=> (f_pc == PC_W'(IRQ_VEC)));

    assert_wb_retire_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_en_o || st_en_o) |-> (retire_o && !(wb_en_o && st_en_o)));
endmodule

// File: tb/fsp_core_tb_top.sv
module fsp_core_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int VEC = 48;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       irq_i = 1'b0;
    logic       prog_we_i = 1'b0;
    logic [5:0] prog_addr_i = '0;
    logic [15:0] prog_data_i = '0;
    logic       retire_o, wb_en_o, st_en_o;
    logic [5:0] retire_pc_o;
    logic [2:0] wb_reg_o;
    logic [7:0] wb_data_o, st_data_o;
    logic [3:0] st_addr_o;

    always #(CLK_PERIOD/2) clk = ~clk;

    fsp_core dut_i (
        .clk(clk), .rst_n(rst_n), .irq_i(irq_i),
        .prog_we_i(prog_we_i), .prog_addr_i(prog_addr_i), .prog_data_i(prog_data_i),
        .retire_o(retire_o), .retire_pc_o(retire_pc_o),
        .wb_en_o(wb_en_o), .wb_reg_o(wb_reg_o), .wb_data_o(wb_data_o),
        .st_en_o(st_en_o), .st_addr_o(st_addr_o), .st_data_o(st_data_o)
    );

    int n_chk = 0;
    int n_fail = 0;
    logic [15:0] tp [64];
    logic [7:0]  mr [8];
    logic [7:0]  mm [16];
    int          mpc, exp_next;
    string       tag;
    bit          last_taken;

    function automatic logic [15:0] e_alu(input int op, input int rd, input int ra, input int rb);
        return {4'(op), 3'(rd), 3'(ra), 3'(rb), 3'b000};
    endfunction
    function automatic logic [15:0] e_ldi(input int rd, input int imm);
        return {4'd3, 3'(rd), 1'b0, 8'(imm)};
    endfunction
    function automatic logic [15:0] e_mem(input int op, input int rd, input int a);
        return {4'(op), 3'(rd), 5'b00000, 4'(a)};
    endfunction
    function automatic logic [15:0] e_bz(input int rd, input int t);
        return {4'd6, 3'(rd), 3'b000, 6'(t)};
    endfunction

    task automatic chk(input bit ok, input string req, input string what, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    task automatic clear_prog();
        for (int a = 0; a < 64; a++) tp[a] = 16'h0000;
    endtask

    // Instruction-level reference step for one retired instruction
    task automatic model_step(input int n);
        logic [15:0] ir;
        int op, rd, ra, rb, nxt, gap;
        bit wbe, ste;
        logic [7:0] v;
        string dtag;
        ir = tp[mpc];
        op = int'(ir[15:12]); rd = int'(ir[11:9]); ra = int'(ir[8:6]); rb = int'(ir[5:3]);
        chk(retire_pc_o == 6'(mpc), tag, "retire pc", int'(retire_pc_o), mpc);
        nxt = (mpc + 1) % 64; gap = 1; wbe = 0; ste = 0; v = '0; dtag = "R9";
        case (op)
            1: begin wbe = 1; v = mr[ra] + mr[rb]; dtag = "R1"; end
            2: begin wbe = 1; v = mr[ra] - mr[rb]; dtag = "R1"; end
            3: begin wbe = 1; v = ir[7:0]; dtag = "R1"; end
            4: begin wbe = 1; v = mm[ir[3:0]]; dtag = "R2"; end
            5: begin ste = 1; v = mr[rd]; dtag = "R2"; end
            6: begin
                if (mr[rd] == 8'd0) begin nxt = int'(ir[5:0]); gap = 4; last_taken = 1; end
                else gap = 3;
            end
            default: ;
        endcase
        chk(wb_en_o == wbe, dtag, "writeback enable", int'(wb_en_o), int'(wbe));
        chk(st_en_o == ste, dtag, "store enable", int'(st_en_o), int'(ste));
        if (wbe) begin
            chk(wb_reg_o == 3'(rd), dtag, "writeback reg", int'(wb_reg_o), rd);
            chk(wb_data_o == v, dtag, "writeback data", int'(wb_data_o), int'(v));
            mr[rd] = v;
        end
        if (ste) begin
            chk(st_addr_o == ir[3:0], dtag, "store addr", int'(st_addr_o), int'(ir[3:0]));
            chk(st_data_o == v, dtag, "store data", int'(st_data_o), int'(v));
            mm[ir[3:0]] = v;
        end
        if (op == 5 && int'(tp[nxt][15:12]) == 4) gap = 2;
        tag = (gap == 4) ? "R5" : (gap == 3) ? "R4" : (gap == 2) ? "R6" : "R3";
        mpc = nxt;
        exp_next = n + gap;
    endtask

    task automatic run_prog(input int ncyc, input int irq_at);
        rst_n = 1'b0; irq_i = 1'b0;
        for (int a = 0; a < 64; a++) begin
            @(negedge clk);
            prog_we_i = 1'b1; prog_addr_i = 6'(a); prog_data_i = tp[a];
        end
        @(negedge clk);
        prog_we_i = 1'b0;
        chk(retire_o == 1'b0, "R3", "retire in reset", int'(retire_o), 0);
        chk(wb_en_o == 1'b0 && st_en_o == 1'b0, "R3", "effects in reset", int'(wb_en_o | st_en_o), 0);
        for (int i = 0; i < 8; i++) mr[i] = 8'd0;
        for (int i = 0; i < 16; i++) mm[i] = 8'(7 * i + 3);
        mpc = 0; exp_next = 4; tag = "R3";
        rst_n = 1'b1;
        for (int n = 1; n <= ncyc; n++) begin
            @(negedge clk);
            last_taken = 0;
            if (retire_o) begin
                chk(n == exp_next, tag, "retire cycle", n, exp_next);
                model_step(n);
            end else if (n == exp_next) begin
                chk(1'b0, tag, "missing retire", 0, 1);
                exp_next = -1;
            end
            if (n == irq_at) begin
                irq_i = 1'b1;
                tag = last_taken ? "R8" : "R7";
                mpc = VEC;
                exp_next = n + 4;
            end else begin
                irq_i = 1'b0;
            end
        end
        irq_i = 1'b0;
    endtask

    initial begin
        int vals [5];
        vals = '{0, 1, 127, 128, 255};
        // R1: arithmetic sweep over boundary operand pairs, plus R9 unused opcode
        for (int i = 0; i < 5; i++) begin
            clear_prog();
            for (int j = 0; j < 5; j++) begin
                tp[4*j]   = e_ldi(1, vals[i]);
                tp[4*j+1] = e_ldi(2, vals[j]);
                tp[4*j+2] = e_alu(1, 3, 1, 2);
                tp[4*j+3] = e_alu(2, 4, 1, 2);
            end
            tp[20] = 16'hF9C0;
            tp[21] = 16'h0000;
            tp[22] = e_bz(0, 22);
            run_prog(40, -1);
        end
        // R2/R6: reset pattern of every data word, store/load contention
        clear_prog();
        for (int a = 0; a < 16; a++) tp[a] = e_mem(4, 1, a);
        tp[16] = e_ldi(2, 8'hA5);
        tp[17] = e_mem(5, 2, 3);
        tp[18] = e_mem(4, 5, 3);
        tp[19] = e_mem(5, 2, 9);
        tp[20] = e_mem(4, 6, 10);
        tp[21] = e_mem(4, 6, 9);
        tp[22] = e_ldi(3, 0);
        tp[23] = e_mem(5, 3, 0);
        tp[24] = e_mem(4, 1, 0);
        tp[25] = e_bz(0, 25);
        run_prog(50, -1);
        // R4/R5: counting loop with taken and fall-through branches
        clear_prog();
        tp[0] = e_ldi(1, 3);
        tp[1] = e_ldi(2, 1);
        tp[2] = e_alu(2, 1, 1, 2);
        tp[3] = e_bz(1, 6);
        tp[4] = e_bz(0, 2);
        tp[5] = e_ldi(7, 8'hEE);
        tp[6] = e_ldi(4, 8'h44);
        tp[7] = e_bz(2, 7);
        tp[8] = e_alu(1, 5, 4, 2);
        tp[9] = e_bz(0, 9);
        run_prog(80, -1);
        // R7/R8: one interrupt pulse swept across every cycle of a mixed program
        clear_prog();
        tp[0] = e_ldi(1, 2);
        tp[1] = e_ldi(2, 1);
        tp[2] = e_mem(5, 1, 5);
        tp[3] = e_mem(4, 3, 5);
        tp[4] = e_alu(2, 1, 1, 2);
        tp[5] = e_bz(1, 7);
        tp[6] = e_bz(0, 2);
        tp[7] = e_bz(0, 7);
        tp[VEC]     = e_ldi(6, 8'h5A);
        tp[VEC + 1] = e_alu(1, 6, 6, 2);
        tp[VEC + 2] = e_bz(0, VEC + 2);
        for (int k = 0; k <= 32; k++) run_prog(50, (k == 0) ? -1 : k);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule